// File: doc/BRIEF.md
# Memory Card Byte-Lane Access Decoder

This block is the card-side access logic of a removable 68-pin memory card. It takes the two active-low card enables, the space select, address bit 0, output enable, write enable and the write-protect switch input, and from them decides which internal byte bank is read or written and on which half of the 16-bit data bus. The low lane enable alone gives an 8-bit access where A0 picks the even or odd byte. The high lane enable alone gives the odd byte on the upper lane. Both together give a full 16-bit word.

Common space is held as an even bank and an odd bank. Attribute space is a separate byte store that holds only even addresses. The bus is modelled as a 16-bit data output plus one drive enable per byte lane, and a lane whose enable is low stands for high impedance. Control and read data are registered: the request sampled at one rising edge sets the lane enables and data until the next edge. A write takes effect at the edge that samples it.

Top module: `memcard_lane_dec`

## Requirements
- R1: While `rst_n` is low at a rising edge, both lane enables are low after that edge and no bank is written.
- R2: With `ce_lo_n`=0 and `ce_hi_n`=1 (byte mode), a read drives only the low lane. It carries the even byte when `addr[0]`=0 and the odd byte when `addr[0]`=1. A write stores `din[7:0]` into the byte chosen the same way.
- R3: With `ce_lo_n`=1 and `ce_hi_n`=0, a read drives only the high lane with the odd byte and ignores `addr[0]`. A write stores `din[15:8]` into the odd byte.
- R4: With both enables low (word mode), a read drives the odd byte on `dout[15:8]` and the even byte on `dout[7:0]`. A write stores both bytes. `addr[0]` is ignored and `addr[CM_AW-1:1]` selects the word.
- R5: With both enables high (standby), neither lane is driven and no write occurs.
- R6: With `oe_n`=1 and `we_n`=1, neither lane is driven, whatever the enables are.
- R7: With `oe_n`=0 and `we_n`=0, the access is a write and neither lane is driven.
- R8: With `space_n`=0, accesses go to the attribute store and not to common space. Even attribute bytes read back what was written.
- R9: In attribute space, an odd-byte read returns 8'hFF on its lane and an odd-byte write is discarded.
- R10: With `wprot`=1, writes to both spaces are suppressed and reads are unchanged.
- R11: Common-space address bits at and above `CM_AW` are ignored, so addresses alias every 2^`CM_AW` bytes.
- R12: Lane enables and read data change only at the first rising edge after the request is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_lo_n | input | 1 | Active-low low-lane card enable |
| ce_hi_n | input | 1 | Active-low high-lane card enable |
| space_n | input | 1 | 0 selects attribute space, 1 selects common space |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| wprot | input | 1 | Write-protect switch, 1 blocks all writes |
| addr | input | 23 | Byte address (A22..A0) |
| din | input | 16 | Host write data |
| dout | output | 16 | Read data, meaningful per lane where enabled |
| drv_lo_en | output | 1 | Drive enable for dout[7:0] |
| drv_hi_en | output | 1 | Drive enable for dout[15:8] |

## Verification
A wrong lane-select state shows at the first edge after a read: the wrong lane enable rises, or the right lane carries the neighbouring byte. A decode slip on the write side stays hidden until a later read of that location. The stimulus therefore pairs every write, blocked write and discarded odd attribute write with a read-back of the affected byte and of its neighbour, one or two cycles later. Aliased addresses and the attribute/common split are read back across the two spaces, so a bit taken from the wrong place shows as foreign data.

// File: rtl/memcard_pkg.sv
// Shared types for the memory card lane decoder.
// Assumes: one byte-lane source per lane, chosen per access.
package memcard_pkg;

    typedef enum logic [1:0] {
        SRC_EVEN = 2'd0,
        SRC_ODD  = 2'd1,
        SRC_ATTR = 2'd2,
        SRC_ONES = 2'd3
    } lane_src_e;

    typedef struct packed {
        logic      wr_even;
        logic      wr_odd;
        logic      wr_attr;
        logic [7:0] odd_wd;
        logic      drv_lo;
        logic      drv_hi;
        lane_src_e lo_src;
        lane_src_e hi_src;
    } access_t;

endpackage

// File: rtl/mc_access_decode.sv
// Combinational decode of one bus request into bank writes, lane drives
// and lane sources. Assumes active-low strobes. A write wins when both
// strobes are low, so the lanes are never driven during a write.
module mc_access_decode
    import memcard_pkg::*;
(
    input  logic        ce_lo_n,
    input  logic        ce_hi_n,
    input  logic        space_n,
    input  logic        a0,
    input  logic        oe_n,
    input  logic        we_n,
    input  logic        wprot,
    input  logic [15:0] din,
    output access_t     acc
);

    logic sel, wr, rd, lo_lane, hi_lane, byte_lo, even_t, odd_t;

    // Classify the request and pick targets and lane sources.
    always_comb begin
        sel     = !(ce_lo_n && ce_hi_n);
        wr      = sel && !we_n && !wprot;
        rd      = sel && !oe_n && we_n;
        lo_lane = !ce_lo_n;
        hi_lane = !ce_hi_n;
        byte_lo = lo_lane && !hi_lane;
        even_t  = (byte_lo && !a0) || (lo_lane && hi_lane);
        odd_t   = (byte_lo && a0) || hi_lane;

        acc         = '0;
        acc.wr_even = wr && space_n && even_t;
        acc.wr_odd  = wr && space_n && odd_t;
        acc.wr_attr = wr && !space_n && even_t;
        acc.odd_wd  = hi_lane ? din[15:8] : din[7:0];
        acc.drv_lo  = rd && lo_lane;
        acc.drv_hi  = rd && hi_lane;
        if (space_n) begin
            acc.lo_src = (byte_lo && a0) ? SRC_ODD : SRC_EVEN;
            acc.hi_src = SRC_ODD;
        end else begin
            acc.lo_src = (byte_lo && a0) ? SRC_ONES : SRC_ATTR;
            acc.hi_src = SRC_ONES;
        end
    end

endmodule

// File: rtl/mc_byte_bank.sv
// Synchronous byte array: write at the edge, registered read of the
// same index (old data when read and write coincide). No reset on contents.
module mc_byte_bank #(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata
);

    localparam int DEPTH = 1 << IDX_W;

    logic [7:0] mem [DEPTH];

    // Store on write, register the addressed byte every cycle.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[idx] <= wdata;
        end
        rdata <= mem[idx];
    end

endmodule

// File: rtl/memcard_lane_dec.sv
// Top of the card access logic: decodes the request, updates the even,
// odd and attribute banks, and registers lane enables and sources.
// Assumes CM_AW >= 2 and AM_AW >= 2; upper address bits alias.
module memcard_lane_dec
    import memcard_pkg::*;
#(
    parameter int CM_AW = 10,
    parameter int AM_AW = 9
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ce_lo_n,
    input  logic        ce_hi_n,
    input  logic        space_n,
    input  logic        oe_n,
    input  logic        we_n,
    input  logic        wprot,
    input  logic [22:0] addr,
    input  logic [15:0] din,
    output logic [15:0] dout,
    output logic        drv_lo_en,
    output logic        drv_hi_en
);

    localparam int CM_IDX_W = CM_AW - 1;
    localparam int AM_IDX_W = AM_AW - 1;
    localparam int NUM_CM   = 2;

    access_t    acc;
    logic [7:0] cm_rd [NUM_CM];
    logic [7:0] am_rd;
    lane_src_e  lo_src_q, hi_src_q;

    mc_access_decode dec_i (
        .ce_lo_n (ce_lo_n),
        .ce_hi_n (ce_hi_n),
        .space_n (space_n),
        .a0      (addr[0]),
        .oe_n    (oe_n),
        .we_n    (we_n),
        .wprot   (wprot),
        .din     (din),
        .acc     (acc)
    );

    // Common space: bank 0 holds even bytes, bank 1 holds odd bytes.
    for (genvar g = 0; g < NUM_CM; g++) begin : g_cm
        mc_byte_bank #(.IDX_W(CM_IDX_W)) bank_i (
            .clk   (clk),
            .wr_en (rst_n && ((g == 0) ? acc.wr_even : acc.wr_odd)),
            .idx   (addr[CM_AW-1:1]),
            .wdata ((g == 0) ? din[7:0] : acc.odd_wd),
            .rdata (cm_rd[g])
        );
    end

    mc_byte_bank #(.IDX_W(AM_IDX_W)) attr_i (
        .clk   (clk),
        .wr_en (rst_n && acc.wr_attr),
        .idx   (addr[AM_AW-1:1]),
        .wdata (din[7:0]),
        .rdata (am_rd)
    );

    // Register lane enables and lane sources alongside the bank read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_lo_en <= 1'b0;
            drv_hi_en <= 1'b0;
            lo_src_q  <= SRC_ONES;
            hi_src_q  <= SRC_ONES;
        end else begin
            drv_lo_en <= acc.drv_lo;
            drv_hi_en <= acc.drv_hi;
            lo_src_q  <= acc.lo_src;
            hi_src_q  <= acc.hi_src;
        end
    end

    // Steer the registered bank data onto each lane.
    always_comb begin
        case (lo_src_q)
            SRC_EVEN: dout[7:0] = cm_rd[0];
            SRC_ODD:  dout[7:0] = cm_rd[1];
            SRC_ATTR: dout[7:0] = am_rd;
            default:  dout[7:0] = 8'hFF;
        endcase
        dout[15:8] = (hi_src_q == SRC_ODD) ? cm_rd[1] : 8'hFF;
    end

endmodule

// File: rtl/memcard_lane_dec_chk.sv
// Port-level properties of the lane decoder, bound to every instance.
module memcard_lane_dec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ce_lo_n,
    input logic        ce_hi_n,
    input logic        space_n,
    input logic        oe_n,
    input logic        we_n,
    input logic [15:0] dout,
    input logic        drv_lo_en,
    input logic        drv_hi_en
);

    // R2
    byte_lo_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_lo_n && ce_hi_n && !oe_n && we_n) |=> (drv_lo_en && !drv_hi_en));

    // R3
    odd_hi_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_lo_n && !ce_hi_n && !oe_n && we_n) |=> (drv_hi_en && !drv_lo_en));

    // R4
    word_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_lo_n && !ce_hi_n && !oe_n && we_n) |=> (drv_lo_en && drv_hi_en));

    // R5
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_lo_n && ce_hi_n) |=> (!drv_lo_en && !drv_hi_en));

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n && we_n) |=> (!drv_lo_en && !drv_hi_en));

    // R7
    write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n) |=> (!drv_lo_en && !drv_hi_en));

    // R9
    attr_odd_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!space_n && !ce_hi_n && !oe_n && we_n) |=> (dout[15:8] == 8'hFF));

endmodule

bind memcard_lane_dec memcard_lane_dec_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_lo_n   (ce_lo_n),
    .ce_hi_n   (ce_hi_n),
    .space_n   (space_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .dout      (dout),
    .drv_lo_en (drv_lo_en),
    .drv_hi_en (drv_hi_en)
);

// File: tb/memcard_lane_dec_tb_top.sv
// Vector-table bench for the lane decoder, followed by directed tests
// for reset and output timing.
module memcard_lane_dec_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NV         = 31;

    typedef struct packed {
        logic        sp, c1, c2, oe, we, wp;
        logic [22:0] addr;
        logic [15:0] din;
        logic        lo, hi;
        logic [15:0] dout;
        logic [3:0]  rq;
    } vec_t;

    // Fields: space_n ce_lo_n ce_hi_n oe_n we_n wprot addr din lo_en hi_en dout req
    localparam vec_t VEC [NV] = '{
        '{1,0,0,1,0,0, 23'h000010, 16'hBBAA, 0,0, 16'h0000, 4'd4},  // R4 word write
        '{1,0,0,0,1,0, 23'h000011, 16'h0000, 1,1, 16'hBBAA, 4'd4},  // R4 read, A0 ignored
        '{1,0,1,0,1,0, 23'h000010, 16'h0000, 1,0, 16'h00AA, 4'd2},  // R2 even
        '{1,0,1,0,1,0, 23'h000011, 16'h0000, 1,0, 16'h00BB, 4'd2},  // R2 odd
        '{1,0,1,1,0,0, 23'h000021, 16'h0055, 0,0, 16'h0000, 4'd2},  // R2 odd write
        '{1,1,0,0,1,0, 23'h000020, 16'h0000, 0,1, 16'h5500, 4'd3},  // R3 A0 ignored
        '{1,1,0,1,0,0, 23'h000020, 16'h6677, 0,0, 16'h0000, 4'd3},  // R3 write high
        '{1,0,1,0,1,0, 23'h000021, 16'h0000, 1,0, 16'h0066, 4'd3},  // R3 readback
        '{1,1,1,1,0,0, 23'h000010, 16'hFFFF, 0,0, 16'h0000, 4'd5},  // R5 standby write
        '{1,0,0,0,1,0, 23'h000010, 16'h0000, 1,1, 16'hBBAA, 4'd5},  // R5 unchanged
        '{1,0,0,1,1,0, 23'h000010, 16'h0000, 0,0, 16'h0000, 4'd6},  // R6 idle
        '{1,0,0,0,0,0, 23'h000030, 16'h1234, 0,0, 16'h0000, 4'd7},  // R7 both low
        '{1,0,0,0,1,0, 23'h000030, 16'h0000, 1,1, 16'h1234, 4'd7},  // R7 stored
        '{1,0,0,1,0,1, 23'h000010, 16'h0000, 0,0, 16'h0000, 4'd10}, // R10 blocked
        '{1,0,0,0,1,1, 23'h000010, 16'h0000, 1,1, 16'hBBAA, 4'd10}, // R10 read ok
        '{1,0,0,0,1,0, 23'h000410, 16'h0000, 1,1, 16'hBBAA, 4'd11}, // R11 alias read
        '{1,0,0,1,0,0, 23'h7FFC30, 16'h5678, 0,0, 16'h0000, 4'd11}, // R11 alias write
        '{1,0,0,0,1,0, 23'h000030, 16'h0000, 1,1, 16'h5678, 4'd11}, // R11 readback
        '{0,0,1,1,0,0, 23'h000010, 16'h00C3, 0,0, 16'h0000, 4'd8},  // R8 attr write
        '{0,0,1,0,1,0, 23'h000010, 16'h0000, 1,0, 16'h00C3, 4'd8},  // R8 attr read
        '{1,0,0,0,1,0, 23'h000010, 16'h0000, 1,1, 16'hBBAA, 4'd8},  // R8 common intact
        '{0,0,1,1,0,0, 23'h000011, 16'h0099, 0,0, 16'h0000, 4'd9},  // R9 odd discarded
        '{0,0,1,0,1,0, 23'h000011, 16'h0000, 1,0, 16'h00FF, 4'd9},  // R9 odd reads FF
        '{0,0,1,0,1,0, 23'h000010, 16'h0000, 1,0, 16'h00C3, 4'd9},  // R9 even intact
        '{0,1,0,1,0,0, 23'h000010, 16'h7700, 0,0, 16'h0000, 4'd9},  // R9 high discarded
        '{0,0,0,0,1,0, 23'h000010, 16'h0000, 1,1, 16'hFFC3, 4'd9},  // R9 word read
        '{0,0,0,1,0,0, 23'h000020, 16'hEE5A, 0,0, 16'h0000, 4'd8},  // R8 attr word write
        '{0,0,1,0,1,0, 23'h000020, 16'h0000, 1,0, 16'h005A, 4'd8},  // R8 readback
        '{0,0,1,1,0,1, 23'h000020, 16'h0011, 0,0, 16'h0000, 4'd10}, // R10 attr blocked
        '{0,0,1,0,1,0, 23'h000020, 16'h0000, 1,0, 16'h005A, 4'd10}, // R10 attr intact
        '{1,1,1,0,1,0, 23'h000010, 16'h0000, 0,0, 16'h0000, 4'd5}   // R5 standby read
    };

    logic        clk = 1'b0;
    logic        rst_n, ce_lo_n, ce_hi_n, space_n, oe_n, we_n, wprot;
    logic [22:0] addr;
    logic [15:0] din, dout;
    logic        drv_lo_en, drv_hi_en;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    memcard_lane_dec dut_i (
        .clk(clk), .rst_n(rst_n), .ce_lo_n(ce_lo_n), .ce_hi_n(ce_hi_n),
        .space_n(space_n), .oe_n(oe_n), .we_n(we_n), .wprot(wprot),
        .addr(addr), .din(din), .dout(dout),
        .drv_lo_en(drv_lo_en), .drv_hi_en(drv_hi_en)
    );

    task automatic check(input bit ok, input string rq, input logic [17:0] act,
                         input logic [17:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        space_n = v.sp; ce_lo_n = v.c1; ce_hi_n = v.c2;
        oe_n = v.oe; we_n = v.we; wprot = v.wp; addr = v.addr; din = v.din;
    endtask

    task automatic check_out(input string rq, input logic lo, input logic hi,
                             input logic [15:0] exp);
        logic [15:0] m;
        m = {{8{hi}}, {8{lo}}};
        check({drv_hi_en, drv_lo_en} == {hi, lo}, rq,
              {drv_hi_en, drv_lo_en, 16'h0}, {hi, lo, 16'h0});
        if (lo || hi) begin
            check((dout & m) == (exp & m), rq, {2'b0, dout & m}, {2'b0, exp & m});
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R12 watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        apply('{1,1,1,1,1,0, 23'h0, 16'h0, 0,0, 16'h0, 4'd0});
        repeat (3) @(negedge clk);
        // R1: reset state
        check_out("R1 reset state", 1'b0, 1'b0, 16'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            @(negedge clk);
            check_out($sformatf("vector %0d req %0d", i, VEC[i].rq),
                      VEC[i].lo, VEC[i].hi, VEC[i].dout);
        end

        // R1: read and write during reset have no effect
        rst_n = 1'b0;
        apply('{1,0,0,0,1,0, 23'h10, 16'h0, 0,0, 16'h0, 4'd1});
        @(negedge clk);
        check_out("R1 read under reset", 1'b0, 1'b0, 16'h0);
        apply('{1,0,0,1,0,0, 23'h10, 16'h0000, 0,0, 16'h0, 4'd1});
        @(negedge clk);
        rst_n = 1'b1;
        apply('{1,0,0,0,1,0, 23'h10, 16'h0, 0,0, 16'h0, 4'd1});
        @(negedge clk);
        check_out("R1 write under reset blocked", 1'b1, 1'b1, 16'hBBAA);

        // R12: outputs change only at the edge after the request
        apply('{1,0,0,1,1,0, 23'h30, 16'h0, 0,0, 16'h0, 4'd12});
        @(negedge clk);
        apply('{1,0,0,0,1,0, 23'h10, 16'h0, 0,0, 16'h0, 4'd12});
        #1;
        check_out("R12 before edge", 1'b0, 1'b0, 16'h0);
        @(negedge clk);
        check_out("R12 after edge", 1'b1, 1'b1, 16'hBBAA);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule